// File: doc/BRIEF.md
# Iterative AES-128 Decryption Core

This block turns one 128-bit AES-128 ciphertext block into its plaintext, doing one cipher round per clock. The host writes the ciphertext as four 32-bit words into an input buffer and then raises `start`. The core does not expand the key. It drives a round-key index to an external key table and expects the matching 128-bit round key on `rk_key` in the same cycle, as from an asynchronous read.

A decryption has three stages. The cycle that accepts `start` adds the last round key (index 10). The next nine cycles each run a full inverse round: inverse row rotation, inverse substitution, key addition, then inverse column mixing. A tenth cycle runs the reduced round, which has no column mixing. One more cycle copies the result into a separate output buffer and raises `done`. The host reads the plaintext back one 32-bit word at a time through `rd_addr`.

The input buffer is cleared when a start is accepted, so the next ciphertext can be written while the current block is being decrypted. The output buffer keeps the previous result until the new one is transferred.

Top module: `aes128_inv_core`

## Requirements
- R1: Reset state. While reset is held and after its release: `done` is 0, `rk_idx` is 10, and `rd_data` is zero for every `rd_addr`.
- R2: Input buffering.
  - Each cycle with `wr_en` high stores `wr_data` into the next free word of the input buffer, while fewer than four words are held.
  - State bytes are column-major, so byte k is row k mod 4, column k div 4. The first word written carries bytes 0 to 3, with byte 0 in bits 31:24.
  - A write made while four words are held is ignored. This includes a write in the same cycle as an accepted start.
- R3: A start is accepted only when all four input words are held. A start with fewer words has no effect on `rk_idx` or `done`.
- R4: Round-key index sequence.
  - `rk_idx` is 10 while idle, including the cycle in which the start is presented.
  - In the ten cycles after the accepting edge it reads 9, 8, …, 0.
- R5: The plaintext equals the AES-128 inverse cipher of the buffered ciphertext under the keys supplied on `rk_key`. It uses the same byte order as R2, and rd_addr 0 returns bytes 0 to 3.
- R6: `done` timing.
  - `done` rises on the 11th rising edge after the edge that accepted the start.
  - `done` is cleared by that accepting edge.
  - At no other time does `done` fall.
- R7: Output buffer hold.
  - `rd_data` changes only when `rd_addr` changes or when a new result is transferred.
  - During a decryption, reads return the previous plaintext.
- R8: A start raised while a decryption is in progress is ignored, even with a full input buffer. The current run's timing and result are unchanged, and the buffered words stay available for the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write one ciphertext word |
| wr_data | input | 32 | Ciphertext word |
| start | input | 1 | Begin decryption of the buffered block |
| rk_idx | output | 4 | Key-expansion step whose round key is needed this cycle |
| rk_key | input | 128 | Round key for `rk_idx`, same byte order as the state |
| done | output | 1 | Plaintext available in the output buffer |
| rd_addr | input | 2 | Plaintext word select |
| rd_data | output | 32 | Selected plaintext word |

## Verification
Buffer writes and start acceptance can land in the same cycle. The bench raises a stray `wr_en` on the very edge that accepts a start. It then writes the next block's four words during the computation and raises a second start mid-run with the buffer full. The pass criterion is indirect: the following run must decrypt exactly the four words written after the accepting edge, with the normal 11-edge latency. Reads of the output buffer also overlap a running decryption, and they must still return the earlier plaintext.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

  localparam int BYTE_W  = 8;
  localparam int ROWS    = 4;
  localparam int COLS    = 4;
  localparam int STATE_W = BYTE_W * ROWS * COLS;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [STATE_W-1:0] state_t;

  // multiply by x in GF(2^8): shift, then reduce when the top bit left
  function automatic byte_t gf_dbl(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse (0 maps to 0)
  function automatic byte_t gf_inv(byte_t a);
    byte_t sq;
    byte_t acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  // inverse substitution: undo the affine map, then invert
  function automatic byte_t inv_sub(byte_t s);
    byte_t t;
    t = {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
    return gf_inv(t);
  endfunction

  // byte k of the state, byte 0 in the top bits
  function automatic byte_t st_byte(state_t s, int k);
    return s[(STATE_W-1) - BYTE_W*k -: BYTE_W];
  endfunction

endpackage

// File: rtl/aes_inv_rstsync.sv
module aes_inv_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/aes_inv_inbuf.sv
module aes_inv_inbuf #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [WORD_W-1:0]       wr_data_i,
  input  logic                    clear_i,
  output logic                    full_o,
  output logic [WORD_W*WORDS-1:0] data_o
);
  localparam int CNT_W = $clog2(WORDS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             accept;

  assign full_o = (cnt_q == CNT_W'(WORDS));
  assign accept = wr_en_i && !full_o;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clear_i || accept;
    if (clear_i)     cnt_d = '0;
    else if (accept) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              word_we;

    assign word_we = accept && (cnt_q == CNT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_we) word_q <= wr_data_i;
    end

    assign data_o[WORD_W*(WORDS-i)-1 -: WORD_W] = word_q;
  end
endmodule

// File: rtl/aes_inv_ctrl.sv
module aes_inv_ctrl #(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             full_i,
  output logic             start_ok_o,
  output logic             rnd_full_o,
  output logic             rnd_last_o,
  output logic             xfer_o,
  output logic [IDX_W-1:0] rk_idx_o
);
  // phase 0 idle, 1..NUM_ROUNDS rounds, NUM_ROUNDS+1 result transfer
  localparam int PH_XFER = NUM_ROUNDS + 1;
  localparam int PH_W    = $clog2(PH_XFER + 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_en;
  logic            idle;

  assign idle       = (ph_q == '0);
  assign start_ok_o = start_i && full_i && idle;
  assign rnd_full_o = !idle && (ph_q < PH_W'(NUM_ROUNDS));
  assign rnd_last_o = (ph_q == PH_W'(NUM_ROUNDS));
  assign xfer_o     = (ph_q == PH_W'(PH_XFER));

  always_comb begin
    ph_d  = ph_q;
    ph_en = start_ok_o || !idle;
    if (start_ok_o)  ph_d = PH_W'(1);
    else if (xfer_o) ph_d = '0;
    else if (!idle)  ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  // round r of decryption uses expansion step NUM_ROUNDS-r
  assign rk_idx_o = (ph_q <= PH_W'(NUM_ROUNDS))
                  ? IDX_W'(NUM_ROUNDS - int'(ph_q)) : '0;
endmodule

// File: rtl/aes_inv_mixcol.sv
module aes_inv_mixcol
  import aes_inv_pkg::*;
(
  input  logic [BYTE_W*ROWS-1:0] col_i,
  output logic [BYTE_W*ROWS-1:0] col_o
);
  localparam int COL_W = BYTE_W * ROWS;

  byte_t a   [ROWS];
  byte_t m9  [ROWS];
  byte_t m11 [ROWS];
  byte_t m13 [ROWS];
  byte_t m14 [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_mul
    byte_t d2, d4, d8;
    assign a[r]   = col_i[COL_W-1-BYTE_W*r -: BYTE_W];
    assign d2     = gf_dbl(a[r]);
    assign d4     = gf_dbl(d2);
    assign d8     = gf_dbl(d4);
    assign m9[r]  = d8 ^ a[r];
    assign m11[r] = d8 ^ d2 ^ a[r];
    assign m13[r] = d8 ^ d4 ^ a[r];
    assign m14[r] = d8 ^ d4 ^ d2;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_sum
    assign col_o[COL_W-1-BYTE_W*r -: BYTE_W] =
        m14[r] ^ m11[(r+1)%ROWS] ^ m13[(r+2)%ROWS] ^ m9[(r+3)%ROWS];
  end
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
  import aes_inv_pkg::*;
(
  input  state_t st_i,
  input  state_t key_i,
  input  logic   last_i,
  output state_t st_o
);
  localparam int COL_W = BYTE_W * ROWS;

  state_t ark;
  state_t mix;

  // row rotation folded into the byte select feeding the substitution
  always_comb begin
    ark = '0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        ark[(STATE_W-1) - BYTE_W*(r + ROWS*c) -: BYTE_W] =
            inv_sub(st_byte(st_i, r + ROWS*((c - r + COLS) % COLS)))
            ^ st_byte(key_i, r + ROWS*c);
      end
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    aes_inv_mixcol u_mix (
      .col_i (ark[(STATE_W-1) - COL_W*c -: COL_W]),
      .col_o (mix[(STATE_W-1) - COL_W*c -: COL_W])
    );
  end

  assign st_o = last_i ? ark : mix;
endmodule

// File: rtl/aes128_inv_core.sv
module aes128_inv_core
  import aes_inv_pkg::*;
#(
  parameter  int WORD_W     = 32,
  parameter  int NUM_ROUNDS = 10,
  localparam int WORDS      = STATE_W / WORD_W,
  localparam int ADDR_W     = $clog2(WORDS),
  localparam int IDX_W      = $clog2(NUM_ROUNDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               start,
  output logic [IDX_W-1:0]   rk_idx,
  input  logic [STATE_W-1:0] rk_key,
  output logic               done,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data
);
  logic   rst_core_n;
  logic   buf_full;
  state_t in_blk;
  logic   start_ok, rnd_full, rnd_last, xfer;
  state_t rnd_out;
  state_t st_q, st_d;
  logic   st_en;
  state_t res_q;
  logic   done_q, done_d;
  logic [WORD_W-1:0] out_words [WORDS];

  aes_inv_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  aes_inv_inbuf #(.WORD_W(WORD_W), .WORDS(WORDS)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .clear_i   (start_ok),
    .full_o    (buf_full),
    .data_o    (in_blk)
  );

  aes_inv_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_i    (start),
    .full_i     (buf_full),
    .start_ok_o (start_ok),
    .rnd_full_o (rnd_full),
    .rnd_last_o (rnd_last),
    .xfer_o     (xfer),
    .rk_idx_o   (rk_idx)
  );

  aes_inv_round u_round (
    .st_i   (st_q),
    .key_i  (rk_key),
    .last_i (rnd_last),
    .st_o   (rnd_out)
  );

  always_comb begin
    st_en = start_ok || rnd_full || rnd_last;
    st_d  = st_q;
    if (start_ok) st_d = in_blk ^ rk_key;
    else if (rnd_full || rnd_last) st_d = rnd_out;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) st_q <= '0;
    else if (st_en)  st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) res_q <= '0;
    else if (xfer)   res_q <= st_q;
  end

  always_comb begin
    done_d = done_q;
    if (start_ok)  done_d = 1'b0;
    else if (xfer) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_out
    assign out_words[i] = res_q[WORD_W*(WORDS-i)-1 -: WORD_W];
  end

  assign rd_data = out_words[rd_addr];
  assign done    = done_q;
endmodule

// File: rtl/aes128_inv_core_chk.sv
module aes128_inv_core_chk #(
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int IDX_W      = 4,
  parameter int NUM_ROUNDS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [IDX_W-1:0]  rk_idx,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WORD_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(NUM_ROUNDS);

  // R4
  rk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rk_idx <= IDLE_IDX);

  // R4
  rk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_idx != IDLE_IDX && rk_idx != '0) |=> (rk_idx == IDX_W'($past(rk_idx) - 1'b1)));

  // R4
  rk_leave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_idx == IDLE_IDX) |=> (rk_idx == IDLE_IDX || rk_idx == IDX_W'(NUM_ROUNDS - 1)));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(rk_idx, 1) == '0 && $past(rk_idx, 2) == '0
                     && $past(rk_idx, 3) == IDX_W'(1)));

  // R6
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> (rk_idx == IDX_W'(NUM_ROUNDS - 1)));

  // R8
  no_busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_idx != IDLE_IDX) |=> !$fell(done));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$rose(done)) |-> $stable(rd_data));
endmodule

bind aes128_inv_core aes128_inv_core_chk #(
  .WORD_W     (WORD_W),
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .NUM_ROUNDS (NUM_ROUNDS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .done    (done),
  .rk_idx  (rk_idx),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/tb_aes128_inv_core.sv
`timescale 1ns/1ps
module tb_aes128_inv_core;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [31:0]  wr_data;
  logic         start;
  logic [3:0]   rk_idx;
  logic [127:0] rk_key;
  logic         done;
  logic [1:0]   rd_addr;
  logic [31:0]  rd_data;

  logic [127:0] rk_tab [16];
  int nchk;
  int nerr;

  // {key, ciphertext, plaintext}
  localparam logic [383:0] VECS [4] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32, 128'h3243f6a8885a308d313198a2e0370734},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3ad77bb40d7a3660a89ecaf32466ef97, 128'h6bc1bee22e409f96e93d7e117393172a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hf5d3d58503b9699de785895a96fdbaaf, 128'hae2d8a571e03ac9c9eb76fac45af8e51}
  };

  aes128_inv_core dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .start   (start),
    .rk_idx  (rk_idx),
    .rk_key  (rk_key),
    .done    (done),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // external key table, asynchronous read
  assign rk_key = rk_tab[rk_idx];

  // ---------------- reference arithmetic for key expansion ----------------
  function automatic logic [7:0] bxt(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = bxt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] fsb(logic [7:0] x);
    logic [7:0] q;
    logic [7:0] r;
    q = x;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      q = bmul(q, q);
      r = bmul(r, q);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
             ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  task automatic load_keys(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {fsb(t[23:16]), fsb(t[15:8]), fsb(t[7:0]), fsb(t[31:24])} ^ {rc, 24'h0};
        rc = bxt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk_tab[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic read_result(output logic [127:0] res);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #0.2;
      res[127-32*a -: 32] = rd_data;
    end
    rd_addr = 2'd0;
  endtask

  task automatic write_word(input logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic write_block(input logic [127:0] blk);
    for (int w = 0; w < 4; w++) write_word(blk[127-32*w -: 32]);
  endtask

  // run one decryption; options overlap other activity with it
  task automatic run_block(input string tag, input logic [127:0] exp_pt,
                           input bit chk_prev, input logic [127:0] prev_pt,
                           input bit stray_wr, input bit wr_next,
                           input logic [127:0] nxt_blk, input bit inj_start);
    int n;
    bit seq_ok;
    logic done1;
    logic [127:0] got;
    logic [127:0] prev_got;
    chk("R4", {tag, " idle index at start"}, 128'(rk_idx), 128'd10);
    start = 1'b1;
    if (stray_wr) begin
      wr_en   = 1'b1;
      wr_data = 32'hdeadbeef;
    end
    @(negedge clk);
    start    = 1'b0;
    wr_en    = 1'b0;
    n        = 1;
    seq_ok   = 1'b1;
    done1    = 1'b1;
    prev_got = '0;
    while (!done && n < 30) begin
      if (n == 1) done1 = done;
      if (n <= 10 && rk_idx != 4'(10 - n)) seq_ok = 1'b0;
      if (chk_prev && n == 3) read_result(prev_got);
      wr_en = 1'b0;
      start = 1'b0;
      if (wr_next && n >= 2 && n <= 5) begin
        wr_en   = 1'b1;
        wr_data = nxt_blk[127-32*(n-2) -: 32];
      end
      if (inj_start && n == 7) start = 1'b1;
      @(negedge clk);
      n++;
    end
    wr_en = 1'b0;
    start = 1'b0;
    chk("R6", {tag, " done cleared after accepted start"}, 128'(done1), 128'd0);
    chk("R6", {tag, " negedges until done"}, 128'(n), 128'd12);
    chk("R4", {tag, " key index sequence 9..0"}, 128'(seq_ok), 128'd1);
    if (chk_prev) chk("R7", {tag, " previous result held during run"}, prev_got, prev_pt);
    read_result(got);
    chk("R5", {tag, " plaintext"}, got, exp_pt);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [127:0] r;
    logic [127:0] last_pt;
    nchk    = 0;
    nerr    = 0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    start   = 1'b0;
    rd_addr = 2'd0;
    for (int i = 0; i < 16; i++) rk_tab[i] = '0;
    repeat (3) @(negedge clk);

    // R1 during reset
    chk("R1", "done in reset", 128'(done), 128'd0);
    chk("R1", "index in reset", 128'(rk_idx), 128'd10);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after reset", 128'(done), 128'd0);
    chk("R1", "index after reset", 128'(rk_idx), 128'd10);
    read_result(r);
    chk("R1", "output buffer after reset", r, '0);

    // R3: start with an empty buffer has no effect
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3", "index after start with empty buffer", 128'(rk_idx), 128'd10);
    @(negedge clk);
    chk("R3", "done after start with empty buffer", 128'(done), 128'd0);

    // vector table walk
    last_pt = '0;
    for (int v = 0; v < 4; v++) begin
      load_keys(VECS[v][383:256]);
      write_block(VECS[v][255:128]);
      run_block($sformatf("vec%0d", v), VECS[v][127:0], v > 0, last_pt,
                1'b0, 1'b0, '0, 1'b0);
      last_pt = VECS[v][127:0];
    end

    // R3: three words only, start ignored; fourth word then completes block
    load_keys(VECS[0][383:256]);
    for (int w = 0; w < 3; w++) write_word(VECS[0][255-32*w -: 32]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3", "index after start with 3 words", 128'(rk_idx), 128'd10);
    @(negedge clk);
    chk("R3", "done kept after start with 3 words", 128'(done), 128'd1);
    write_word(VECS[0][159:128]);
    run_block("partial", VECS[0][127:0], 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);

    // R2: a fifth write is ignored
    load_keys(VECS[1][383:256]);
    write_block(VECS[1][255:128]);
    write_word(32'h0badf00d);
    run_block("overflow", VECS[1][127:0], 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);

    // R2 + R8: stray write on the accepting edge, next block written
    // during the run, and a start mid-run with the buffer full
    write_block(VECS[2][255:128]);
    run_block("overlap", VECS[2][127:0], 1'b1, VECS[1][127:0],
              1'b1, 1'b1, VECS[3][255:128], 1'b1);
    // the words written during the run must still be intact and exact
    run_block("after-overlap", VECS[3][127:0], 1'b1, VECS[2][127:0],
              1'b0, 1'b0, '0, 1'b0);

    // R7: reads stay stable when idle
    read_result(r);
    repeat (5) @(negedge clk);
    begin
      logic [127:0] r2;
      read_result(r2);
      chk("R7", "output stable while idle", r2, r);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule